// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block records which physical registers of an out-of-order core are currently unallocated, so the rename stage can pick destination registers. Three register classes are kept apart: integer, floating point and condition code. Each class owns a first-in first-out pool of free global register indices. The global index space is split into contiguous ranges. Integer indices start at zero, floating-point indices follow immediately, and condition-code indices come after the floating-point range.

Each class presents its oldest free index as a valid/ready output stream. Valid is high exactly when the pool holds at least one entry, and the index stays put until a transfer. A transfer happens on a clock edge where valid and ready are both high. Raising ready while valid is low is an illegal allocation: the pool is left untouched and an error flag pulses. A generic release port takes one freed global index and sorts it into a pool by range. That port has a ready that drops in any cycle where a per-class release is presented. The per-class release ports are plain strobes that push straight into one pool without looking at the index, and they are always accepted. At reset each pool is filled with its class's indices in ascending order, minus the lowest few per class that the initial architectural mappings hold.

Top module: `phys_free_list`

## Requirements
- R1: After reset, the pool for each class holds that class's indices from (class base + reserved count) to (class base + class size - 1) in ascending order. With the defaults the counts are 4, 4 and 3, and the heads are 4, 12 and 17.
- R2: Each pool is first-in first-out. The output index of a class is its oldest entry, and a transfer (valid and ready both high) removes it and decrements the count by one.
- R3: A generic release that is accepted goes to the integer pool for indices 0 to N_INT-1, to the floating-point pool for N_INT to N_INT+N_FP-1, and to the condition-code pool for N_INT+N_FP to N_INT+N_FP+N_CC-1. With the defaults these ranges are 0-7, 8-15 and 16-19.
- R4: An accepted generic release with an index of N_INT+N_FP+N_CC or above is discarded and raises err_range_o for exactly the following cycle.
- R5: A per-class release pushes its index into that class's pool whatever its value. While any per-class release strobe is high, rel_ready_o is low and the generic release does not take effect.
- R6: Asserting ready on a class whose pool is empty leaves that pool unchanged and raises that class's bit of err_empty_o for the following cycle.
- R7: free_cnt_o reports each pool's number of entries, updated one clock after the transfer. free_avail_o bit c is high exactly when that count is non-zero. Bit order is 0 integer, 1 floating point, 2 condition code.
- R8: When an allocation and a release hit the same pool in one cycle, both take effect and the count is unchanged. The index handed out that cycle is the prior head, never the index being released.
- R9: Releasing an index already present in a pool is not detected. The index is appended again and can later be allocated twice.
- R10: A release into a full pool in a cycle without an allocation from that pool is dropped and the count stays at the class size. With CHK_OVF=1 that class's bit of err_ovf_o pulses for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| free_avail_o | output | 3 | Per-class stream valid: pool non-empty |
| alloc_ready_i | input | 3 | Per-class stream ready: take the head index |
| alloc_idx_o | output | 3*IW | Per-class head index, class c in bits [c*IW +: IW] |
| rel_valid_i | input | 1 | Generic release valid |
| rel_ready_o | output | 1 | Generic release ready, low while any per-class release is valid |
| rel_idx_i | input | IW | Generic released global index |
| crel_valid_i | input | 3 | Per-class release strobes |
| crel_idx_i | input | 3*IW | Per-class released indices |
| free_cnt_o | output | 3*CW | Per-class free counts, class c in bits [c*CW +: CW] |
| err_empty_o | output | 3 | Allocation attempted from an empty pool (one-cycle pulse) |
| err_ovf_o | output | 3 | Release into a full pool (one-cycle pulse, when CHK_OVF=1) |
| err_range_o | output | 1 | Generic release outside all class ranges (one-cycle pulse) |

## Verification
The bench releases indices at both edges of every class range, and one just past the last range. A classifier with an off-by-one boundary would put those indices into a neighbouring pool, and that shows up as wrong counts. It drains a pool and then allocates once more. A design that lets the pointers move on an empty pool would report a wrapped count or a stale index. It allocates and releases the same pool in one cycle, both when the pool holds a single entry and when it is full. A design that forwards the released index would return it at once, and one that sees only "full" would drop it. It releases an index twice and checks that both copies come back in order, which a design that silently removed duplicates would fail.

// File: rtl/phys_free_list_pkg.sv
package phys_free_list_pkg;
  localparam int NUM_CLS = 3;
  localparam int CLS_INT = 0;
  localparam int CLS_FP  = 1;
  localparam int CLS_CC  = 2;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fl_classify.sv
module fl_classify #(
  parameter int IW    = 5,
  parameter int N_INT = 8,
  parameter int N_FP  = 8,
  parameter int N_CC  = 4
) (
  input  logic [IW-1:0] idx_i,
  output logic [2:0]    sel_o,
  output logic          bad_o
);
  localparam int FP_BASE = N_INT;
  localparam int CC_BASE = N_INT + N_FP;
  localparam int TOTAL   = N_INT + N_FP + N_CC;

  logic [31:0] wide_idx;

  always_comb begin
    wide_idx = 32'(idx_i);
    sel_o    = 3'b000;
    bad_o    = 1'b0;
    if (wide_idx < 32'(FP_BASE))      sel_o[phys_free_list_pkg::CLS_INT] = 1'b1;
    else if (wide_idx < 32'(CC_BASE)) sel_o[phys_free_list_pkg::CLS_FP]  = 1'b1;
    else if (wide_idx < 32'(TOTAL))   sel_o[phys_free_list_pkg::CLS_CC]  = 1'b1;
    else                              bad_o = 1'b1;
  end
endmodule

// File: rtl/fl_pool.sv
module fl_pool #(
  parameter int DEPTH = 8,
  parameter int BASE  = 0,
  parameter int RSV   = 4,
  parameter int IW    = 5,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic [CW-1:0] cnt_o,
  output logic          avail_o,
  output logic          under_o,
  output logic          over_o
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int INIT = DEPTH - RSV;

  logic [IW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          empty, full, do_pop, do_push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign under_o = pop_i && empty;
  assign over_o  = push_i && !do_push;
  assign head_o  = slot_q[rd_q];
  assign cnt_o   = cnt_q;
  assign avail_o = !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slot_q[i] <= (i < INIT) ? IW'(BASE + RSV + i) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT % DEPTH);
      cnt_q <= CW'(INIT);
    end else begin
      if (do_push) begin
        slot_q[wr_q] <= push_idx_i;
        wr_q         <= bump(wr_q);
      end
      if (do_pop) rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list #(
  parameter int N_INT   = 8,
  parameter int N_FP    = 8,
  parameter int N_CC    = 4,
  parameter int R_INT   = 4,
  parameter int R_FP    = 4,
  parameter int R_CC    = 1,
  parameter int CHK_OVF = 1,
  localparam int TOTAL  = N_INT + N_FP + N_CC,
  localparam int IW     = $clog2(TOTAL),
  localparam int CW     = $clog2(phys_free_list_pkg::max3(N_INT, N_FP, N_CC) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [2:0]     free_avail_o,
  input  logic [2:0]     alloc_ready_i,
  output logic [3*IW-1:0] alloc_idx_o,
  input  logic           rel_valid_i,
  output logic           rel_ready_o,
  input  logic [IW-1:0]  rel_idx_i,
  input  logic [2:0]     crel_valid_i,
  input  logic [3*IW-1:0] crel_idx_i,
  output logic [3*CW-1:0] free_cnt_o,
  output logic [2:0]     err_empty_o,
  output logic [2:0]     err_ovf_o,
  output logic           err_range_o
);
  localparam int DEPTHS [3] = '{N_INT, N_FP, N_CC};
  localparam int BASES  [3] = '{0, N_INT, N_INT + N_FP};
  localparam int RSVS   [3] = '{R_INT, R_FP, R_CC};

  logic [2:0] sel;
  logic       bad, rel_go;
  logic [2:0] under, over, push;
  logic [IW-1:0] push_idx [3];
  logic [2:0] err_empty_q, err_ovf_q;
  logic       err_range_q;

  fl_classify #(.IW(IW), .N_INT(N_INT), .N_FP(N_FP), .N_CC(N_CC)) u_cls (
    .idx_i(rel_idx_i), .sel_o(sel), .bad_o(bad)
  );

  assign rel_ready_o = ~|crel_valid_i;
  assign rel_go      = rel_valid_i && rel_ready_o;

  for (genvar c = 0; c < 3; c++) begin : g_pool
    assign push[c]     = crel_valid_i[c] | (rel_go & sel[c]);
    assign push_idx[c] = crel_valid_i[c] ? crel_idx_i[c*IW +: IW] : rel_idx_i;

    fl_pool #(
      .DEPTH(DEPTHS[c]), .BASE(BASES[c]), .RSV(RSVS[c]), .IW(IW), .CW(CW)
    ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push[c]),
      .push_idx_i(push_idx[c]),
      .pop_i     (alloc_ready_i[c]),
      .head_o    (alloc_idx_o[c*IW +: IW]),
      .cnt_o     (free_cnt_o[c*CW +: CW]),
      .avail_o   (free_avail_o[c]),
      .under_o   (under[c]),
      .over_o    (over[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_empty_q <= '0;
      err_ovf_q   <= '0;
      err_range_q <= 1'b0;
    end else begin
      err_empty_q <= under;
      err_ovf_q   <= (CHK_OVF != 0) ? over : 3'b000;
      err_range_q <= rel_go & bad;
    end
  end

  assign err_empty_o = err_empty_q;
  assign err_ovf_o   = err_ovf_q;
  assign err_range_o = err_range_q;
endmodule

// File: rtl/phys_free_list_chk.sv
module phys_free_list_chk #(
  parameter int N_INT   = 8,
  parameter int N_FP    = 8,
  parameter int N_CC    = 4,
  parameter int CHK_OVF = 1,
  parameter int IW      = 5,
  parameter int CW      = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      free_avail_o,
  input logic [2:0]      alloc_ready_i,
  input logic            rel_valid_i,
  input logic            rel_ready_o,
  input logic [IW-1:0]   rel_idx_i,
  input logic [2:0]      crel_valid_i,
  input logic [3*CW-1:0] free_cnt_o,
  input logic [2:0]      err_empty_o,
  input logic [2:0]      err_ovf_o,
  input logic            err_range_o
);
  localparam int TOTAL = N_INT + N_FP + N_CC;
  localparam int DEPTHS [3] = '{N_INT, N_FP, N_CC};

  AST_REL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|crel_valid_i) |-> !rel_ready_o); // R5

  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid_i && rel_ready_o && (32'(rel_idx_i) >= 32'(TOTAL))) |=> err_range_o); // R4

  for (genvar c = 0; c < 3; c++) begin : g_cls
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt_o[c*CW +: CW] <= CW'(DEPTHS[c])); // R7

    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ready_i[c] && free_avail_o[c] && !crel_valid_i[c] && !rel_valid_i)
      |=> free_cnt_o[c*CW +: CW] == $past(free_cnt_o[c*CW +: CW]) - CW'(1)); // R2

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ready_i[c] && !free_avail_o[c] && !crel_valid_i[c] && !rel_valid_i)
      |=> err_empty_o[c] && free_cnt_o[c*CW +: CW] == '0); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (crel_valid_i[c] && !alloc_ready_i[c] && free_cnt_o[c*CW +: CW] == CW'(DEPTHS[c]))
      |=> (err_ovf_o[c] == (CHK_OVF != 0)) && free_cnt_o[c*CW +: CW] == CW'(DEPTHS[c])); // R10
  end
endmodule

bind phys_free_list phys_free_list_chk #(
  .N_INT(N_INT), .N_FP(N_FP), .N_CC(N_CC), .CHK_OVF(CHK_OVF), .IW(IW), .CW(CW)
) u_chk (.*);

// File: tb/phys_free_list_bench.sv
module phys_free_list_bench;
  localparam int PERIOD = 10;
  localparam int IW = 5;
  localparam int CW = 4;
  localparam int NV = 12;

  // {take[2:0], relv, relidx, crelv[2:0], crelidx, head int, head fp, head cc, cnt int, cnt fp, cnt cc, err_range}
  localparam logic [44:0] VEC [NV] = '{
    {3'b001, 1'b0, 5'd0,  3'b000, 5'd0, 5'd4, 5'd12, 5'd17, 4'd3, 4'd4, 4'd3, 1'b0}, // R2
    {3'b011, 1'b1, 5'd4,  3'b000, 5'd0, 5'd5, 5'd12, 5'd17, 4'd3, 4'd3, 4'd3, 1'b0}, // R3 R8
    {3'b000, 1'b1, 5'd18, 3'b000, 5'd0, 5'd6, 5'd13, 5'd17, 4'd3, 4'd3, 4'd4, 1'b0}, // R9
    {3'b100, 1'b1, 5'd12, 3'b000, 5'd0, 5'd6, 5'd13, 5'd17, 4'd3, 4'd4, 4'd3, 1'b0}, // R3
    {3'b000, 1'b1, 5'd25, 3'b000, 5'd0, 5'd6, 5'd13, 5'd18, 4'd3, 4'd4, 4'd3, 1'b1}, // R4
    {3'b000, 1'b1, 5'd0,  3'b001, 5'd9, 5'd6, 5'd13, 5'd18, 4'd4, 4'd4, 4'd3, 1'b0}, // R5
    {3'b111, 1'b0, 5'd0,  3'b000, 5'd0, 5'd6, 5'd13, 5'd18, 4'd3, 4'd3, 4'd2, 1'b0}, // R2
    {3'b001, 1'b1, 5'd7,  3'b000, 5'd0, 5'd7, 5'd14, 5'd19, 4'd3, 4'd3, 4'd2, 1'b0}, // R3 R8
    {3'b000, 1'b1, 5'd8,  3'b000, 5'd0, 5'd4, 5'd14, 5'd19, 4'd3, 4'd4, 4'd2, 1'b0}, // R3
    {3'b000, 1'b1, 5'd16, 3'b000, 5'd0, 5'd4, 5'd14, 5'd19, 4'd3, 4'd4, 4'd3, 1'b0}, // R3
    {3'b000, 1'b1, 5'd19, 3'b000, 5'd0, 5'd4, 5'd14, 5'd19, 4'd3, 4'd4, 4'd4, 1'b0}, // R3
    {3'b000, 1'b1, 5'd20, 3'b000, 5'd0, 5'd4, 5'd14, 5'd19, 4'd3, 4'd4, 4'd4, 1'b1}  // R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] free_avail, alloc_ready = '0, crel_valid = '0;
  logic [3*IW-1:0] alloc_idx, crel_idx = '0;
  logic rel_valid = 1'b0, rel_ready, err_range;
  logic [IW-1:0] rel_idx = '0;
  logic [3*CW-1:0] free_cnt;
  logic [2:0] err_empty, err_ovf;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  phys_free_list u_phys_free_list (
    .clk(clk), .rst_n(rst_n), .free_avail_o(free_avail), .alloc_ready_i(alloc_ready),
    .alloc_idx_o(alloc_idx), .rel_valid_i(rel_valid), .rel_ready_o(rel_ready),
    .rel_idx_i(rel_idx), .crel_valid_i(crel_valid), .crel_idx_i(crel_idx),
    .free_cnt_o(free_cnt), .err_empty_o(err_empty), .err_ovf_o(err_ovf),
    .err_range_o(err_range)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int head(input int c);
    return int'(alloc_idx[c*IW +: IW]);
  endfunction

  function automatic int cnt(input int c);
    return int'(free_cnt[c*CW +: CW]);
  endfunction

  task automatic idle();
    alloc_ready = '0; rel_valid = 1'b0; rel_idx = '0; crel_valid = '0; crel_idx = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cc_push(input int idx);
    crel_valid = 3'b100; crel_idx = '0; crel_idx[2*IW +: IW] = IW'(idx);
  endtask

  task automatic check_reset(input string tag);
    check({tag, " cnt int"}, cnt(0), 4);
    check({tag, " cnt fp"}, cnt(1), 4);
    check({tag, " cnt cc"}, cnt(2), 3);
    check({tag, " head int"}, head(0), 4);
    check({tag, " head fp"}, head(1), 12);
    check({tag, " head cc"}, head(2), 17);
    check({tag, " avail"}, int'(free_avail), 7);
    check({tag, " errors"}, int'({err_empty, err_ovf, err_range}), 0);
  endtask

  initial begin : watchdog
    #(PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [44:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_reset("R1");

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      alloc_ready = v[44:42]; rel_valid = v[41]; rel_idx = v[40:36];
      crel_valid = v[35:33];
      crel_idx = '0;
      for (int c = 0; c < 3; c++) crel_idx[c*IW +: IW] = v[32:28];
      #1;
      check("R2 head int", head(0), int'(v[27:23]));
      check("R2 head fp", head(1), int'(v[22:18]));
      check("R2 head cc", head(2), int'(v[17:13]));
      check("R5 rel_ready", int'(rel_ready), int'(~|v[35:33]));
      tick();
      check("R3 R7 cnt int", cnt(0), int'(v[12:9]));
      check("R3 R7 cnt fp", cnt(1), int'(v[8:5]));
      check("R3 R7 cnt cc", cnt(2), int'(v[4:1]));
      check("R4 err_range", int'(err_range), int'(v[0]));
    end
    idle();
    // state now: int [4,9,7], fp [14,15,12,8], cc [19,18,16,19]

    cc_push(3); // R10 full pool, no allocation
    tick(); idle();
    check("R10 err_ovf", int'(err_ovf), 4);
    check("R10 cnt cc", cnt(2), 4);
    #1; check("R10 head cc", head(2), 19);

    cc_push(2); alloc_ready = 3'b100; // R8 full pool, push and pop
    #1; check("R8 head before", head(2), 19);
    tick(); idle();
    check("R8 no ovf", int'(err_ovf), 0);
    check("R8 cnt cc", cnt(2), 4);

    begin : drain // R2 R9 duplicate 19 comes back
      int exp_q [4] = '{18, 16, 19, 2};
      for (int k = 0; k < 4; k++) begin
        alloc_ready = 3'b100;
        #1; check("R2 R9 drain head", head(2), exp_q[k]);
        tick(); idle();
      end
    end
    check("R7 cnt empty", cnt(2), 0);
    check("R7 avail empty", int'(free_avail), 3);

    alloc_ready = 3'b100; // R6
    tick(); idle();
    check("R6 err_empty", int'(err_empty), 4);
    check("R6 cnt cc", cnt(2), 0);
    check("R6 cnt int", cnt(0), 3);
    check("R6 avail", int'(free_avail), 3);

    cc_push(11);
    tick(); idle();
    #1; check("R5 head cc", head(2), 11);
    check("R5 cnt cc", cnt(2), 1);

    cc_push(10); alloc_ready = 3'b100; // R8 single entry
    #1; check("R8 returns old head", head(2), 11);
    tick(); idle();
    check("R8 cnt cc", cnt(2), 1);
    #1; check("R8 new head", head(2), 10);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1; check_reset("R1 again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule